// File: doc/BRIEF.md
# Write-only two-wire bus slave receiver

This block is the receive front end of a device that can only be written to over a two-wire bus with a clock line and a data line. Both lines are first synchronized into the system clock domain. A stable-count filter then removes short spikes from each line. The filtered lines are watched for bus conditions:
- START: data falls while the clock is high.
- STOP: data rises while the clock is high.

Bytes arrive most significant bit first, one bit per rising clock edge. The first byte after any START holds a 7-bit device address and a direction bit.

The device address has two parts. The upper four bits are fixed at 0101. In the four-channel build, the low three bits come from strap pins. In the eight-channel build, the fifth bit is fixed at 0 and only two strap pins are used. A match with the direction bit at 0 makes the block addressed. It then acknowledges the address byte and every later byte by pulling the data line low during the ninth clock. Any other address byte leaves the block silent until the next START. A repeated START always sends the block back to address matching.

Received data bytes leave through a valid/ready stream. The block offers no back-pressure to the bus, since it does not stretch the clock. A byte is held on `rx_data` until `rx_ready` accepts it. If a newer byte completes while the old one is still held, the newer byte replaces it. START and STOP are reported as one-cycle pulses. STOP is reported only while the block is addressed.

Top module: `tw_wr_slave`

## Requirements
- R1: A change on either bus line reaches the condition detectors only after it has been steady for FILT_CYC system clocks (13 by default, 52 ns at 250 MHz). A shorter pulse is dropped: it produces no START, no STOP and no extra bit.
- R2: `start_pulse` is high for one cycle on every START, whether it is the first START or a repeated one, and whether or not the block is addressed. `start_pulse` and `stop_pulse` are never high together.
- R3: In the four-channel build (OCTAL=0), the address byte, most significant bit first, is accepted when it equals {0101, strap_addr[2:0], 0}. The block then drives `sda_pull` high during the ninth clock of that byte.
- R4: In the eight-channel build (OCTAL=1), the address byte is accepted when it equals {0101, 0, strap_addr[1:0], 0}. strap_addr[2] plays no part in the match.
- R5: An address byte that does not match, or has its last bit at 1 (read), gets no acknowledge. Later bytes then get no acknowledge and deliver nothing, and the following STOP is not reported. This holds until the next START.
- R6: While addressed, every completed data byte is acknowledged and delivered on `rx_data`, most significant bit first. `rx_first` is 1 for the first data byte after the address and 0 for later bytes.
- R7: `sda_pull` rises only at the falling clock edge that ends the eighth bit. It stays high until the falling clock edge that ends the ninth clock, or until a START or STOP.
- R8: `stop_pulse` is high for one cycle on a STOP only while the block is addressed. A repeated START followed by an address for another device clears the addressed state, so the next STOP is not reported.
- R9: A STOP that arrives after one to seven bits of a byte delivers no byte and raises `stop_partial` together with `stop_pulse`. The clock high phase in which the STOP occurs does not count as a bit. A STOP on a byte boundary leaves `stop_partial` at 0.
- R10: `rx_valid` rises the cycle after a byte completes. `rx_valid` and `rx_data` then hold until a cycle with `rx_ready` high, or until a newer byte replaces the held one.
- R11: After reset, `sda_pull`, `rx_valid`, `start_pulse`, `stop_pulse` and `stop_partial` are 0, and the filtered lines start at the idle level (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| strap_addr | input | 3 | Strap pins for the low address bits |
| sda_pull | output | 1 | Open-drain enable: 1 drives the data line low |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Downstream accepts the held byte |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Byte is the first data byte after the address |
| start_pulse | output | 1 | One-cycle pulse per START |
| stop_pulse | output | 1 | One-cycle pulse per STOP while addressed |
| stop_partial | output | 1 | With stop_pulse: STOP cut a byte short |

## Verification
The assertions check on every cycle that the acknowledge enable is only set or released at the allowed points, and that a delivered byte is always acknowledged. They also check that START and STOP pulses never coincide, that a partial flag never appears without a STOP, and that a held byte stays stable under back-pressure. Only the bench scenarios can show the rest. Those scenarios cover which address bytes are acknowledged in each build, byte contents and first-byte marking, suppression of STOP after a mismatch or a repeated START, spike rejection on both lines, and partial-byte STOP accounting.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] ADDR_PREFIX = 4'b0101;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 13,
  parameter bit IDLE_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   raw;

  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE_VAL}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end
  end

  // output follows the synchronized line only after FILT_CYC steady cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      line_out <= IDLE_VAL;
    end else if (raw == line_out) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q    <= '0;
      line_out <= raw;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/tw_rx_engine.sv
module tw_rx_engine
  import tw_pkg::*;
#(
  parameter bit OCTAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_bit,
  input  logic [2:0]        strap,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_first,
  output logic              sda_pull,
  output logic              stop_seen,
  output logic              stop_partial
);
  localparam logic [3:0] CNT_BYTE = 4'(BYTE_W);
  localparam logic [3:0] CNT_ACK  = 4'(BYTE_W + 1);

  rx_state_e         state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              first_q;
  logic [6:0]        own_addr;
  logic              addr_hit;

  // the build variant decides which strap pins enter the address
  if (OCTAL) begin : g_oct
    assign own_addr = {ADDR_PREFIX, 1'b0, strap[1:0]};
  end else begin : g_quad
    assign own_addr = {ADDR_PREFIX, strap};
  end

  assign addr_hit = (shreg_q[BYTE_W-1:1] == own_addr) && !shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      shreg_q      <= '0;
      first_q      <= 1'b0;
      sda_pull     <= 1'b0;
      byte_stb     <= 1'b0;
      byte_data    <= '0;
      byte_first   <= 1'b0;
      stop_seen    <= 1'b0;
      stop_partial <= 1'b0;
    end else begin
      byte_stb     <= 1'b0;
      stop_seen    <= 1'b0;
      stop_partial <= 1'b0;
      if (start_evt) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        first_q  <= 1'b1;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        if (state_q == ST_DATA) begin
          stop_seen <= 1'b1;
          // the clock phase carrying the STOP has already bumped the count
          stop_partial <= (cnt_q >= 4'd2) && (cnt_q <= CNT_BYTE);
        end
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        sda_pull <= 1'b0;
      end else if (state_q == ST_ADDR || state_q == ST_DATA) begin
        if (scl_rise && cnt_q < CNT_BYTE) begin
          shreg_q <= {shreg_q[BYTE_W-2:0], sda_bit};
          cnt_q   <= cnt_q + 1'b1;
        end else if (scl_fall && cnt_q == CNT_BYTE) begin
          cnt_q <= CNT_ACK;
          if (state_q == ST_ADDR) begin
            if (addr_hit) begin
              state_q  <= ST_DATA;
              sda_pull <= 1'b1;
            end else begin
              state_q <= ST_SKIP;
            end
          end else begin
            sda_pull   <= 1'b1;
            byte_stb   <= 1'b1;
            byte_data  <= shreg_q;
            byte_first <= first_q;
            first_q    <= 1'b0;
          end
        end else if (scl_fall && cnt_q == CNT_ACK) begin
          cnt_q    <= '0;
          sda_pull <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tw_wr_slave.sv
module tw_wr_slave
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 13,
  parameter bit OCTAL       = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap_addr,
  output logic              sda_pull,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_first,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              stop_partial
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_l, filt_l;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              byte_stb, byte_first;
  logic [BYTE_W-1:0] byte_data;

  assign raw_l = {scl_in, sda_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    tw_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC),
      .IDLE_VAL   (1'b1)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (raw_l[g]),
      .line_out(filt_l[g])
    );
  end

  tw_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (filt_l[1]),
    .sda_f    (filt_l[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  tw_rx_engine #(.OCTAL(OCTAL)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .sda_bit     (filt_l[0]),
    .strap       (strap_addr),
    .byte_stb    (byte_stb),
    .byte_data   (byte_data),
    .byte_first  (byte_first),
    .sda_pull    (sda_pull),
    .stop_seen   (stop_pulse),
    .stop_partial(stop_partial)
  );

  assign start_pulse = start_evt;

  // single holding slot: a newer byte overwrites an unaccepted one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_first <= 1'b0;
    end else if (byte_stb) begin
      rx_valid <= 1'b1;
      rx_data  <= byte_data;
      rx_first <= byte_first;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_wr_slave_chk.sv
module tw_wr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       byte_stb,
  input logic       sda_pull,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       stop_partial
);
  // R2
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));

  // R9
  partial_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_partial |-> stop_pulse);

  // R6
  byte_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> sda_pull);

  // R7
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull && !scl_fall && !start_evt && !stop_evt) |=> sda_pull);

  // R7
  pull_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !byte_stb) |=> (rx_valid && $stable(rx_data)));

  // R10
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> rx_valid);
endmodule

bind tw_wr_slave tw_wr_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_fall    (scl_fall),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .byte_stb    (byte_stb),
  .sda_pull    (sda_pull),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .start_pulse (start_pulse),
  .stop_pulse  (stop_pulse),
  .stop_partial(stop_partial)
);

// File: tb/tw_wr_slave_tb.sv
`timescale 1ns/1ps
module tw_wr_slave_tb;
  localparam int Q = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic rx_ready = 1'b1;
  logic [2:0] strap = 3'b110;
  logic line;
  logic pull_q, pull_o;
  logic rx_valid, rx_first, start_pulse, stop_pulse, stop_partial;
  logic [7:0] rx_data;
  logic o_valid, o_first, o_start, o_stop, o_part;
  logic [7:0] o_data;

  int n_checks = 0;
  int n_fail = 0;
  int n_rx = 0, n_start = 0, n_stop = 0, n_part = 0;
  logic [7:0] log_data [16];
  logic       log_first [16];

  always #2 clk = ~clk;

  assign line = sda_m & ~pull_q & ~pull_o;

  tw_wr_slave #(.OCTAL(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line), .strap_addr(strap),
    .sda_pull(pull_q), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_first(rx_first), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .stop_partial(stop_partial));

  tw_wr_slave #(.OCTAL(1'b1)) u_dut_oct (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line), .strap_addr(strap),
    .sda_pull(pull_o), .rx_valid(o_valid), .rx_ready(1'b1), .rx_data(o_data),
    .rx_first(o_first), .start_pulse(o_start), .stop_pulse(o_stop),
    .stop_partial(o_part));

  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_valid && rx_ready) begin
        if (n_rx < 16) begin
          log_data[n_rx]  <= rx_data;
          log_first[n_rx] <= rx_first;
        end
        n_rx <= n_rx + 1;
      end
      if (start_pulse) n_start <= n_start + 1;
      if (stop_pulse) n_stop <= n_stop + 1;
      if (stop_pulse && stop_partial) n_part <= n_part + 1;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_bit(input bit b, input bit gl);
    sda_m = b;
    if (gl) begin
      wait_clk(4); scl_m = 1'b1; wait_clk(6); scl_m = 1'b0; wait_clk(Q-10);
    end else begin
      wait_clk(Q);
    end
    scl_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit aq, output bit ao);
    for (int i = 7; i >= 0; i--) send_bit(b[i], gl);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    aq = pull_q; ao = pull_o;
    wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic t_reset();
    chk(pull_q == 1'b0, "R11 pull", int'(pull_q), 0);
    chk(rx_valid == 1'b0, "R11 valid", int'(rx_valid), 0);
    chk(n_start == 0 && n_stop == 0, "R11 pulses", n_start + n_stop, 0);
  endtask

  task automatic t_write_two();
    bit aq, ao;
    int r0 = n_rx, s0 = n_stop, p0 = n_part;
    bus_start();
    send_byte(8'h5C, 1'b0, aq, ao);
    chk(aq, "R3 quad addr ack", int'(aq), 1);
    chk(!ao, "R4 octal silent on quad addr", int'(ao), 0);
    send_byte(8'hA5, 1'b0, aq, ao);
    chk(aq, "R6 data ack", int'(aq), 1);
    send_byte(8'h3C, 1'b0, aq, ao);
    bus_stop(); wait_clk(40);
    chk(n_rx == r0 + 2, "R6 byte count", n_rx - r0, 2);
    chk(log_data[r0] == 8'hA5 && log_first[r0], "R6 first byte", int'(log_data[r0]), 'hA5);
    chk(log_data[r0+1] == 8'h3C && !log_first[r0+1], "R6 second byte", int'(log_data[r0+1]), 'h3C);
    chk(n_stop == s0 + 1, "R8 stop reported", n_stop - s0, 1);
    chk(n_part == p0, "R9 boundary stop not partial", n_part - p0, 0);
  endtask

  task automatic t_octal();
    bit aq, ao;
    int r0 = n_rx, s0 = n_stop;
    bus_start();
    send_byte(8'h54, 1'b0, aq, ao);
    chk(ao, "R4 octal addr ack (strap2 ignored)", int'(ao), 1);
    chk(!aq, "R5 quad silent on other addr", int'(aq), 0);
    send_byte(8'h11, 1'b0, aq, ao);
    chk(ao && !aq, "R5 later byte only octal acks", int'(aq), 0);
    bus_stop(); wait_clk(40);
    chk(n_rx == r0, "R5 no bytes delivered", n_rx - r0, 0);
    chk(n_stop == s0, "R8 stop hidden when not addressed", n_stop - s0, 0);
  endtask

  task automatic t_read();
    bit aq, ao;
    int r0 = n_rx, s0 = n_stop;
    bus_start();
    send_byte(8'h5D, 1'b0, aq, ao);
    chk(!aq, "R5 read bit not acked", int'(aq), 0);
    send_byte(8'h77, 1'b0, aq, ao);
    chk(!aq, "R5 byte after read not acked", int'(aq), 0);
    bus_stop(); wait_clk(40);
    chk(n_rx == r0 && n_stop == s0, "R5 read silent", n_stop - s0, 0);
  endtask

  task automatic t_restart();
    bit aq, ao;
    int r0 = n_rx, s0 = n_stop, st0 = n_start;
    bus_start();
    send_byte(8'h5C, 1'b0, aq, ao);
    send_byte(8'h42, 1'b0, aq, ao);
    bus_start();
    send_byte(8'h5E, 1'b0, aq, ao);
    chk(!aq, "R8 other addr after restart", int'(aq), 0);
    bus_stop(); wait_clk(40);
    chk(n_start == st0 + 2, "R2 repeated start pulses", n_start - st0, 2);
    chk(n_stop == s0, "R8 stop after restart hidden", n_stop - s0, 0);
    chk(n_rx == r0 + 1 && log_data[r0] == 8'h42, "R6 byte before restart", int'(log_data[r0]), 'h42);
  endtask

  task automatic t_partial();
    bit aq, ao;
    int r0 = n_rx, s0 = n_stop, p0 = n_part;
    bus_start();
    send_byte(8'h5C, 1'b0, aq, ao);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    bus_stop(); wait_clk(40);
    chk(n_stop == s0 + 1, "R9 stop reported", n_stop - s0, 1);
    chk(n_part == p0 + 1, "R9 partial flag", n_part - p0, 1);
    chk(n_rx == r0, "R9 no byte", n_rx - r0, 0);
  endtask

  task automatic t_glitch();
    bit aq, ao;
    int st0 = n_start, s0 = n_stop, r0;
    sda_m = 1'b0; wait_clk(8); sda_m = 1'b1; wait_clk(60);
    chk(n_start == st0, "R1 short sda spike ignored", n_start - st0, 0);
    sda_m = 1'b0; wait_clk(20); sda_m = 1'b1; wait_clk(60);
    chk(n_start == st0 + 1, "R1 long sda pulse is start", n_start - st0, 1);
    chk(n_stop == s0, "R8 unaddressed stop hidden", n_stop - s0, 0);
    r0 = n_rx;
    bus_start();
    send_byte(8'h5C, 1'b0, aq, ao);
    send_byte(8'h96, 1'b1, aq, ao);
    bus_stop(); wait_clk(40);
    chk(n_rx == r0 + 1 && log_data[r0] == 8'h96, "R1 scl spikes ignored", int'(log_data[r0]), 'h96);
  endtask

  task automatic t_backpressure();
    bit aq, ao;
    rx_ready = 1'b0;
    bus_start();
    send_byte(8'h5C, 1'b0, aq, ao);
    send_byte(8'hE1, 1'b0, aq, ao);
    wait_clk(40);
    chk(rx_valid && rx_data == 8'hE1, "R10 held byte", int'(rx_data), 'hE1);
    send_byte(8'h1E, 1'b0, aq, ao);
    wait_clk(40);
    chk(rx_valid && rx_data == 8'h1E, "R10 newer byte replaces", int'(rx_data), 'h1E);
    rx_ready = 1'b1;
    wait_clk(2);
    chk(!rx_valid, "R10 accepted clears valid", int'(rx_valid), 0);
    bus_stop(); wait_clk(40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(40);
    t_reset();
    t_write_two();
    t_octal();
    t_read();
    t_restart();
    t_partial();
    t_glitch();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule